// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between the register side of a processor core and a data memory that is 32 bits wide and addressed in words. For each request it adds a sign-extended 16-bit displacement to a 32-bit base value to form the byte address of the access. It decides whether a word access is aligned, and it produces the word address and the write byte enables. For stores it places the register data on the right byte lanes.

For loads it keeps the two low address bits and the kind of extension for one cycle. This matches a memory that returns read data one cycle after the request. In that cycle it picks the addressed byte out of the returned word and widens it to 32 bits, with either sign or zero extension.

Byte lanes are numbered big-endian. Byte offset 0 inside a word is bits 31:24 and drives byte-enable bit 3. Only word accesses can be misaligned; a byte access is always legal.

Top module: `be_lsu_aligner`

## Requirements
- R1: For every request, `mem_addr` equals (base + sign-extended 16-bit offset) shifted right by 2, in modulo-2^32 arithmetic. This holds for negative offsets too.
- R2: Operation codes are 0 load word, 1 store word, 2 signed byte load, 3 unsigned byte load and 4 byte store. A word operation (code 0 or 1) whose byte address has nonzero low two bits raises `misalign`. It drives `mem_we` and `mem_re` low, and it gives no `load_valid` in the next cycle.
- R3: A byte operation (codes 2, 3, 4) never raises `misalign`, whatever the low address bits are.
- R4: An aligned word store drives `mem_we` high, `mem_be` = 4'b1111 and `mem_wdata` equal to the store data.
- R5: A byte store with byte offset k (low two address bits) drives `mem_we` high and `mem_be` with only bit (3 - k) set. It drives `mem_wdata` as four copies of store data bits 7:0.
- R6: An accepted load drives `mem_re` high in its request cycle. `load_valid` is high in the following cycle. For a word load, `load_data` equals `mem_rdata` in that cycle.
- R7: A signed byte load with offset k returns `mem_rdata` bits [31-8k : 24-8k] in bits 7:0 of `load_data`. Bits 31:8 hold copies of that byte's bit 7.
- R8: An unsigned byte load with offset k returns the same byte in bits 7:0 of `load_data`, with bits 31:8 at zero.
- R9: With `req_valid` low, or with an operation code of 5 to 7, `mem_we`, `mem_re`, `misalign` and `mem_be` are all zero, and `load_valid` is low in the next cycle.
- R10: While reset is held and right after it, `load_valid` is low and `load_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte displacement |
| req_wdata | input | 32 | Register data for stores |
| mem_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Byte enables, bit 3 = offset 0 |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 32 | Lane-steered write data |
| misalign | output | 1 | Word access on non-multiple-of-4 address |
| mem_rdata | input | 32 | Read word, one cycle after `mem_re` |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |

## Verification
The request-side outputs (`mem_addr`, `mem_be`, `mem_we`, `mem_re`, `mem_wdata` and `misalign`) are combinational. The bench therefore samples them in the request cycle, a short delay after it drives the inputs on the falling edge. The load result comes one register later. The bench drops the request, presents `mem_rdata` on the next falling edge, and samples `load_valid` and `load_data` after that, which is the single cycle the result is due. The sweeps cover every byte offset with several byte patterns, signed and negative displacements, and all word misalignments.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
    localparam int LANE_BITS = 2;

    typedef enum logic [2:0] {
        OP_LW  = 3'd0,
        OP_SW  = 3'd1,
        OP_LB  = 3'd2,
        OP_LBU = 3'd3,
        OP_SB  = 3'd4
    } lsu_op_e;

    // Context held across the one-cycle memory read latency
    typedef struct packed {
        logic                 valid;
        logic                 sext;
        logic                 word;
        logic [LANE_BITS-1:0] lane;
    } ld_ctx_t;
endpackage

// File: rtl/be_lsu_agu.sv
module be_lsu_agu
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-3:0] word_addr,
    output logic [1:0]        lane,
    output logic              is_word,
    output logic              is_load,
    output logic              is_store,
    output logic              sext,
    output logic              bad_align
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff_addr;
    logic              legal;

    always_comb begin
        eff_addr  = base + {{EXT_W{offset[OFF_W-1]}}, offset};
        word_addr = eff_addr[ADDR_W-1:2];
        lane      = eff_addr[1:0];
        legal     = req_valid && (req_op <= OP_SB);
        is_word   = legal && (req_op == OP_LW || req_op == OP_SW);
        is_load   = legal && (req_op == OP_LW || req_op == OP_LB || req_op == OP_LBU);
        is_store  = legal && (req_op == OP_SW || req_op == OP_SB);
        sext      = (req_op == OP_LB);
        bad_align = is_word && (eff_addr[1:0] != 2'b00);
    end

    // R3: a byte access never reports misalignment
    always_comb begin
        if (legal && !is_word)
            assert_byte_never_misaligned_R3: assert (!bad_align);
    end
endmodule

// File: rtl/be_lsu_store_steer.sv
module be_lsu_store_steer #(
    parameter int DATA_W = 32
) (
    input  logic                  is_word,
    input  logic [1:0]            lane,
    input  logic [DATA_W-1:0]     wdata_in,
    output logic [DATA_W-1:0]     wdata_out,
    output logic [DATA_W/8-1:0]   be
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] byte_hit;

    // Big-endian: lane index i drives enable bit LANES-1-i
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign byte_hit[LANES-1-i] = (lane == i[1:0]);
    end

    always_comb begin
        if (is_word) begin
            wdata_out = wdata_in;
            be        = '1;
        end else begin
            wdata_out = {LANES{wdata_in[7:0]}};
            be        = byte_hit;
        end
    end
endmodule

// File: rtl/be_lsu_load_extract.sv
module be_lsu_load_extract
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ld_ctx_t           ctx,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] lane_byte [LANES];
    logic [7:0] picked;

    for (genvar i = 0; i < LANES; i++) begin : g_pick
        assign lane_byte[i] = rdata[DATA_W-1-8*i -: 8];
    end

    always_comb begin
        picked = lane_byte[ctx.lane];
        if (!ctx.valid)
            result = '0;
        else if (ctx.word)
            result = rdata;
        else if (ctx.sext)
            result = {{(DATA_W-8){picked[7]}}, picked};
        else
            result = {{(DATA_W-8){1'b0}}, picked};
    end

    // R7 / R8: the upper bits of a byte result are a pure extension
    always_comb begin
        if (ctx.valid && !ctx.word && ctx.sext)
            assert_signed_fill_R7: assert (result[DATA_W-1:8] == {(DATA_W-8){result[7]}});
        if (ctx.valid && !ctx.word && !ctx.sext)
            assert_zero_fill_R8: assert (result[DATA_W-1:8] == '0);
    end
endmodule

// File: rtl/be_lsu_aligner.sv
module be_lsu_aligner
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [ADDR_W-3:0]    mem_addr,
    output logic [DATA_W/8-1:0]  mem_be,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 misalign,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 load_valid,
    output logic [DATA_W-1:0]    load_data
);
    localparam int LANES = DATA_W / 8;

    logic              is_word, is_load, is_store, sext, bad_align;
    logic [1:0]        lane;
    logic [LANES-1:0]  steer_be;
    ld_ctx_t           ctx_d, ctx_q;

    be_lsu_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) agu_i (
        .req_valid (req_valid),
        .req_op    (req_op),
        .base      (req_base),
        .offset    (req_offset),
        .word_addr (mem_addr),
        .lane      (lane),
        .is_word   (is_word),
        .is_load   (is_load),
        .is_store  (is_store),
        .sext      (sext),
        .bad_align (bad_align)
    );

    be_lsu_store_steer #(.DATA_W(DATA_W)) steer_i (
        .is_word   (is_word),
        .lane      (lane),
        .wdata_in  (req_wdata),
        .wdata_out (mem_wdata),
        .be        (steer_be)
    );

    always_comb begin
        misalign    = bad_align;
        mem_we      = is_store && !bad_align;
        mem_re      = is_load && !bad_align;
        mem_be      = (mem_we || mem_re) ? steer_be : '0;
        ctx_d.valid = mem_re;
        ctx_d.sext  = sext;
        ctx_d.word  = is_word;
        ctx_d.lane  = lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    be_lsu_load_extract #(.DATA_W(DATA_W)) extract_i (
        .ctx    (ctx_q),
        .rdata  (mem_rdata),
        .result (load_data)
    );

    assign load_valid = ctx_q.valid;

    assert_no_write_when_misaligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && !mem_re));
    assert_result_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> load_valid);
    assert_no_result_without_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !load_valid);
    assert_store_enable_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == '1));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_we && !mem_re && !misalign && mem_be == '0));
endmodule

// File: tb/be_lsu_aligner_tb.sv
module be_lsu_aligner_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic        mem_we, mem_re, misalign, load_valid;
    logic [31:0] mem_wdata, mem_rdata = '0, load_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    be_lsu_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .misalign(misalign), .mem_rdata(mem_rdata),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request, checks request-side outputs, then the next-cycle result
    task automatic access(input logic [2:0] op, input logic [31:0] base, input logic [15:0] off,
                          input logic [31:0] sdata, input logic [31:0] rword, input bit valid);
        logic [31:0] ea;
        logic [1:0]  k;
        bit word_op, byte_op, legal, bad, ld;
        logic [7:0]  b;
        ea = base + {{16{off[15]}}, off};
        k = ea[1:0];
        legal = valid && op <= 3'd4;
        word_op = legal && (op == 3'd0 || op == 3'd1);
        byte_op = legal && !word_op;
        bad = word_op && k != 2'b00;
        ld = legal && !bad && (op == 3'd0 || op == 3'd2 || op == 3'd3);
        @(negedge clk);
        req_valid = valid; req_op = op; req_base = base; req_offset = off; req_wdata = sdata;
        #2;
        if (legal) chk(mem_addr == ea[31:2], "R1 address", {2'b0, mem_addr}, {2'b0, ea[31:2]});
        if (word_op) begin
            chk(misalign == bad, "R2 misalign", {31'b0, misalign}, {31'b0, bad});
            if (bad) chk(!mem_we && !mem_re, "R2 strobes off", {30'b0, mem_we, mem_re}, 32'h0);
        end
        if (byte_op) chk(!misalign, "R3 byte never misaligned", {31'b0, misalign}, 32'h0);
        if (op == 3'd1 && word_op && !bad)
            chk(mem_we && mem_be == 4'hF && mem_wdata == sdata, "R4 word store",
                mem_wdata ^ {28'b0, mem_be}, sdata ^ 32'hF);
        if (op == 3'd4 && byte_op)
            chk(mem_we && mem_be == (4'b1000 >> k) && mem_wdata == {4{sdata[7:0]}}, "R5 byte store",
                {mem_be, mem_wdata[27:0]}, {4'b1000 >> k, {4{sdata[7:0]}}[27:0]});
        if (!legal)
            chk(!mem_we && !mem_re && !misalign && mem_be == 4'h0, "R9 no access",
                {28'b0, mem_be} | {29'b0, mem_we, mem_re, misalign}, 32'h0);
        if (ld) chk(mem_re, "R6 read strobe", {31'b0, mem_re}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0; mem_rdata = rword;
        #2;
        chk(load_valid == ld, ld ? "R6 load_valid" : "R9 R2 no load_valid",
            {31'b0, load_valid}, {31'b0, ld});
        if (ld) begin
            b = rword[31 - 8*k -: 8];
            if (op == 3'd0) chk(load_data == rword, "R6 word load", load_data, rword);
            if (op == 3'd2) chk(load_data == {{24{b[7]}}, b}, "R7 signed byte", load_data, {{24{b[7]}}, b});
            if (op == 3'd3) chk(load_data == {24'b0, b}, "R8 unsigned byte", load_data, {24'b0, b});
        end
    endtask

    function automatic logic [31:0] pat(input int n);
        case (n % 4)
            0: return 32'h807FFF01;
            1: return 32'h12E4569A;
            2: return 32'hC3_00_7E_81;
            default: return 32'h5A_A5_0F_F0 ^ (n * 32'h01010101);
        endcase
    endfunction

    initial begin
        // R10: reset state
        #3;
        chk(!load_valid && load_data == 32'h0, "R10 reset", load_data | {31'b0, load_valid}, 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!load_valid && load_data == 32'h0, "R10 after reset", load_data | {31'b0, load_valid}, 32'h0);

        // R1/R2: word ops across signed displacements and all low-bit patterns
        for (int o = -9; o <= 9; o++) begin
            access(3'd0, 32'h0000_1000, o[15:0], 32'h0, pat(o + 20), 1'b1);
            access(3'd1, 32'h0000_0203, o[15:0], pat(o + 30), 32'h0, 1'b1);
        end
        access(3'd0, 32'h0000_0100, 16'hFFFC, 32'h0, 32'hDEADBEEF, 1'b1);
        access(3'd1, 32'h0000_0000, 16'h8000, 32'hCAFEF00D, 32'h0, 1'b1);
        access(3'd0, 32'hFFFF_FFFC, 16'h0008, 32'h0, 32'h0BADF00D, 1'b1);

        // R3/R5/R7/R8: every byte lane under several patterns
        for (int p = 0; p < 8; p++) begin
            for (int l = 0; l < 4; l++) begin
                access(3'd2, 32'h0000_4000 + l, 16'h0000, 32'h0, pat(p), 1'b1);
                access(3'd3, 32'h0000_4010, l[15:0], 32'h0, pat(p), 1'b1);
                access(3'd4, 32'h0000_5000, 16'hFFF0 + l[15:0], pat(p + 1), 32'h0, 1'b1);
            end
        end

        // R9: reserved codes and idle requests
        for (int c = 5; c < 8; c++) access(c[2:0], 32'h40, 16'h1, 32'h11223344, 32'h55667788, 1'b1);
        access(3'd0, 32'h40, 16'h0, 32'h0, 32'h12345678, 1'b0);
        access(3'd4, 32'h41, 16'h0, 32'hFF, 32'h0, 1'b0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule